// File: doc/BRIEF.md
# Prioritizing Vectored Interrupt Manager

This block collects level-sensitive requests from up to `NCH` peripheral channels and presents the most urgent one to a processor. Each channel can be enabled or disabled on its own and is routed to one of two active-low request outputs: the normal interrupt line `irq_n` or the fast interrupt line `fiq_n`. Among the pending, enabled channels on each line, the lowest-numbered channel wins.

Software dispatches in one of three ways. It can read an index register, which holds the winning channel plus one, with zero meaning that nothing is pending. It can read a vector register that returns the handler address for that channel from an internal table. Or it can let the processor take the handler address straight from the direct-vector port. Every table entry is stored with an even-parity bit. A corrupt entry is never handed out: a programmable fallback address takes its place, and a sticky error flag records the event.

The register interface is a simple single-cycle bus with byte addresses. Reads return data one clock after the read strobe.

Top module: `irq_vector_mgr`

## Requirements
- R1: The mask-set words (0x020 + 4k) and mask-clear words (0x040 + 4k) act only on bits written as 1. A 1 at bit j of word k enables or disables channel 32k+j, and a 0 leaves that channel as it was. Reading either word returns the current enables of channels 32k to 32k+31.
- R2: The pending word 0x080 + 4k returns the registered product of request and enable. A channel's pending bit follows its request one clock later, and a request on a disabled channel never becomes pending.
- R3: The route word 0x060 + 4k holds one select bit per channel. A 1 sends that channel to the fast line and a 0 sends it to the normal line, so each pending channel drives exactly one of the two lines.
- R4: The index registers (0x000 for the normal line, 0x004 for the fast line) read as the lowest-numbered pending channel on that line plus one. They read as 0 when that line has nothing pending.
- R5: `irq_n`/`fiq_n` are low only while their line has a pending channel. A line falls two clocks after its request is applied. When its only request drops, the pending bit clears one clock later and the line rises two clocks later.
- R6: The vector registers 0x008 (normal) and 0x00C (fast) return the table entry of the winning channel on that line. They return the fallback address (0x010) when the index is 0.
- R7: `dvec` always equals bits [31:2] of the normal-line vector value, the same value that register 0x008 would return.
- R8: A table entry with bad parity is replaced by the fallback address in the vector registers and on `dvec`. A bus read that meets such an entry (through 0x008, 0x00C or the table) sets the sticky flag (`perr`, bit 0 of 0x014). Writing 1 to bit 0 of 0x014 clears the flag, and writing 0 has no effect on it.
- R9: A request that drops and rises again within the release window is not lost. Its channel is pending again, and its line is asserted again, once the new level has passed through the pending stage.
- R10: Table entry c is written and read at 0x400 + 4c with correct parity. Writing at 0x800 + 4c stores the same data with inverted parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Level request from each channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| irq_n | output | 1 | Active-low normal interrupt request |
| fiq_n | output | 1 | Active-low fast interrupt request |
| dvec | output | 30 | Direct handler address bits [31:2] for the normal line |
| perr | output | 1 | Sticky vector-table parity error flag |

## Verification
The bench builds the block with 40 channels. This leaves the second enable, route and pending word only partly filled, so it is reached with few table entries to program. A channel in that upper word (channel 35) is enabled and raised, so the word-to-bit mapping is exercised past the first 32 channels. The bench measures the assert and release lags of the request lines at single-cycle resolution. It also drops and re-raises a source within the release window, injects a parity fault in one table entry, and follows that entry through the fast vector register and the direct port.

// File: rtl/irq_vector_mgr.sv
module irq_vector_mgr #(
  parameter int NCH = 96,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq_n,
  output logic           fiq_n,
  output logic [29:0]    dvec,
  output logic           perr
);
  localparam int IW = $clog2(NCH + 1);
  localparam int TW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int W_IIDX = 0, W_FIDX = 1, W_IVEC = 2, W_FVEC = 3, W_FB = 4, W_ERR = 5;
  localparam int W_MSET = 8, W_MCLR = 16, W_SEL = 24, W_PEND = 32;
  localparam int W_TBL = 256, W_BAD = 512;

  logic [NCH-1:0] mask, fsel, pend;
  logic [32:0]    tbl [NCH];
  logic [31:0]    fb, rnext, ivec, fvec;
  logic [IW-1:0]  irq_idx, fiq_idx;
  logic [32:0]    ient, fent, tent;
  logic           ibad, fbad, tbad, in_tbl, hit;
  int             wi;

  wire wr = bus_sel & bus_wr;
  wire rd = bus_sel & ~bus_wr;

  function automatic logic [IW-1:0] pick(input logic [NCH-1:0] v);
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) pick = IW'(i + 1);
  endfunction

  assign wi      = int'(bus_addr[AW-1:2]);
  assign irq_idx = pick(pend & ~fsel);
  assign fiq_idx = pick(pend & fsel);

  assign ient = (irq_idx != '0) ? tbl[TW'(irq_idx - 1'b1)] : '0;
  assign fent = (fiq_idx != '0) ? tbl[TW'(fiq_idx - 1'b1)] : '0;
  assign ibad = (irq_idx != '0) && (^ient);
  assign fbad = (fiq_idx != '0) && (^fent);
  assign ivec = (irq_idx == '0 || ibad) ? fb : ient[31:0];
  assign fvec = (fiq_idx == '0 || fbad) ? fb : fent[31:0];
  assign dvec = ivec[31:2];

  assign in_tbl = (wi >= W_TBL) && (wi < W_TBL + NCH);
  assign tent   = tbl[TW'(wi - W_TBL)];
  assign tbad   = ^tent;
  assign hit    = rd && ((wi == W_IVEC && ibad) || (wi == W_FVEC && fbad) || (in_tbl && tbad));

  always_comb begin
    rnext = '0;
    if (wi == W_IIDX) rnext = 32'(irq_idx);
    if (wi == W_FIDX) rnext = 32'(fiq_idx);
    if (wi == W_IVEC) rnext = ivec;
    if (wi == W_FVEC) rnext = fvec;
    if (wi == W_FB)   rnext = fb;
    if (wi == W_ERR)  rnext = {31'd0, perr};
    if (in_tbl)       rnext = tent[31:0];
    for (int c = 0; c < NCH; c++) begin
      if (wi == W_MSET + c / 32 || wi == W_MCLR + c / 32) rnext[c % 32] = mask[c];
      if (wi == W_SEL + c / 32)  rnext[c % 32] = fsel[c];
      if (wi == W_PEND + c / 32) rnext[c % 32] = pend[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      fsel      <= '0;
      pend      <= '0;
      fb        <= '0;
      bus_rdata <= '0;
      irq_n     <= 1'b1;
      fiq_n     <= 1'b1;
      perr      <= 1'b0;
      for (int c = 0; c < NCH; c++) tbl[c] <= '0;
    end else begin
      pend  <= req_i & mask;
      irq_n <= (irq_idx == '0);
      fiq_n <= (fiq_idx == '0);
      if (rd) bus_rdata <= rnext;
      if (hit) perr <= 1'b1;
      else if (wr && wi == W_ERR && bus_wdata[0]) perr <= 1'b0;
      if (wr && wi == W_FB) fb <= bus_wdata;
      for (int c = 0; c < NCH; c++) begin
        if (wr && wi == W_MSET + c / 32 && bus_wdata[c % 32]) mask[c] <= 1'b1;
        if (wr && wi == W_MCLR + c / 32 && bus_wdata[c % 32]) mask[c] <= 1'b0;
        if (wr && wi == W_SEL + c / 32) fsel[c] <= bus_wdata[c % 32];
        if (wr && wi == W_TBL + c) tbl[c] <= {^bus_wdata, bus_wdata};
        if (wr && wi == W_BAD + c) tbl[c] <= {~^bus_wdata, bus_wdata};
      end
    end
  end
endmodule

module irq_vector_mgr_chk #(
  parameter int NCH = 96,
  parameter int AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] fsel,
  input logic           irq_n,
  input logic           fiq_n,
  input logic           perr,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata
);
  wire clr_err = bus_sel && bus_wr && (int'(bus_addr[AW-1:2]) == 5) && bus_wdata[0];

  assert_pend_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(req_i)) == '0);
  assert_irq_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~fsel) == '0) |=> irq_n);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past((pend & ~fsel) != '0));
  assert_fiq_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & fsel) == '0) |=> fiq_n);
  assert_perr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !clr_err) |=> perr);
endmodule

bind irq_vector_mgr irq_vector_mgr_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/sim_irq_vector_mgr.sv
module sim_irq_vector_mgr;
  localparam int NCH = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_n, fiq_n, perr;
  logic [29:0] dvec;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;
  localparam logic [31:0] FB = 32'hDEAD_BEEC;

  irq_vector_mgr #(.NCH(NCH), .AW(12)) u0 (.*);

  always #10ns clk = ~clk;

  function automatic logic [31:0] tv(input int c);
    return 32'h1000_0000 + 32'(c) * 32'h100;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  initial begin
    #(20ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk({31'd0, irq_n}, 1, "R5 reset irq_n");
    chk({31'd0, fiq_n}, 1, "R5 reset fiq_n");
    chk({31'd0, perr}, 0, "R8 reset perr");
    rd(12'h000, 0, "R4 reset irq index");
    rd(12'h004, 0, "R4 reset fiq index");
    rd(12'h020, 0, "R1 reset mask");

    for (int c = 0; c < NCH; c++) wr(12'h400 + 12'(4 * c), tv(c));
    wr(12'h010, FB);
    rd(12'h414, tv(5), "R10 table read ch5");
    rd(12'h010, FB, "R6 fallback read");

    wr(12'h020, 32'h28);
    rd(12'h020, 32'h28, "R1 set bits 3,5");
    wr(12'h020, 32'h0);
    rd(12'h020, 32'h28, "R1 zero set no effect");
    wr(12'h040, 32'h8);
    rd(12'h040, 32'h20, "R1 clear bit 3");
    wr(12'h040, 32'h0);
    rd(12'h020, 32'h20, "R1 zero clear no effect");
    wr(12'h020, 32'h8);
    wr(12'h024, 32'h8);
    rd(12'h024, 32'h8, "R1 upper word ch35");

    req_i[7] = 1'b1;
    step(3);
    rd(12'h080, 0, "R2 masked req not pending");
    chk({31'd0, irq_n}, 1, "R2 masked req no irq");
    req_i[7] = 1'b0;

    @(negedge clk);
    req_i[3] = 1'b1; req_i[5] = 1'b1;
    step(1);
    chk({31'd0, irq_n}, 1, "R5 irq_n not yet low");
    chk({2'b0, dvec}, {2'b0, tv(3) >> 2}, "R7 direct vector ch3");
    step(1);
    chk({31'd0, irq_n}, 0, "R5 irq_n low after two");
    rd(12'h080, 32'h28, "R2 pending word");
    rd(12'h000, 4, "R4 lowest wins ch3");
    rd(12'h008, tv(3), "R6 irq vector ch3");

    req_i[3] = 1'b0;
    step(2);
    rd(12'h000, 6, "R4 next winner ch5");

    wr(12'h060, 32'h20);
    step(1);
    chk({31'd0, fiq_n}, 0, "R3 fiq_n low");
    chk({31'd0, irq_n}, 1, "R3 irq_n released");
    rd(12'h004, 6, "R3 fiq index ch5");
    rd(12'h000, 0, "R4 irq index empty");
    rd(12'h00C, tv(5), "R6 fiq vector ch5");
    rd(12'h008, FB, "R6 empty irq vector fallback");
    chk({2'b0, dvec}, {2'b0, FB >> 2}, "R7 direct vector fallback");

    req_i[35] = 1'b1;
    step(2);
    rd(12'h000, 36, "R4 upper channel ch35");
    rd(12'h084, 32'h8, "R2 pending upper word");
    req_i[35] = 1'b0;
    step(2);

    @(negedge clk);
    req_i[5] = 1'b0;
    step(1);
    chk({31'd0, fiq_n}, 0, "R5 fiq_n held one cycle");
    rd(12'h080, 0, "R5 pending cleared");
    chk({31'd0, fiq_n}, 1, "R5 fiq_n released");

    req_i[5] = 1'b1;
    step(3);
    chk({31'd0, fiq_n}, 0, "R9 steady fiq");
    req_i[5] = 1'b0;
    step(1);
    req_i[5] = 1'b1;
    step(3);
    chk({31'd0, fiq_n}, 0, "R9 re-raise fiq_n low");
    rd(12'h004, 6, "R9 re-raise index kept");

    wr(12'h814, tv(5));
    rd(12'h00C, FB, "R8 bad parity fallback");
    chk({31'd0, perr}, 1, "R8 perr set");
    rd(12'h014, 1, "R8 status set");
    rd(12'h414, tv(5), "R10 raw table data");
    wr(12'h014, 0);
    rd(12'h014, 1, "R8 zero write keeps flag");
    wr(12'h014, 1);
    rd(12'h014, 0, "R8 one write clears");
    wr(12'h060, 32'h0);
    step(1);
    chk({2'b0, dvec}, {2'b0, FB >> 2}, "R8 direct vector fallback");
    chk({31'd0, perr}, 0, "R8 port read does not flag");

    req_i = '0;
    step(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule